// File: doc/BRIEF.md
# External Pin Interrupt Sense Unit

This unit monitors a group of external interrupt pins. It gives each pin its own sense mode: low level, falling edge, rising edge, or either edge. Each pin passes through a two-stage synchroniser before detection. When the programmed condition is seen, the unit latches a per-pin pending bit. While that bit is set, it drives an active-high level request toward a parent interrupt controller.

Software uses a small 32-bit register bus. A mode word holds the sense selection. A pending word shows the latched events. Writing a zero to a pending bit clears it; writing a one leaves the bit as it is. In low-level mode the condition is re-evaluated on every cycle. A clear therefore only sticks once the pin has gone high again. If a new event and a clear reach the same bit in the same cycle, the event is kept.

Top module: `pin_sense_top`

## Requirements
- R1: After reset every mode field and every pending bit reads 0 and all `irq_o` bits are low. The synchroniser stages reset to logic high, so pins held high after reset raise no request.
- R2: Pending register at byte offset 0x10: pin n at bit n. Mode register at offset 0x14: pin n at bits [2n+1:2n]. Register bits above the implemented pins read 0. Any other offset reads 0, and writes to it change nothing.
- R3: Mode code 0 (low level): the pending bit is set on every cycle the synchronised pin is low.
- R4: Mode code 1 (falling edge): a high-to-low transition of the synchronised pin sets the pending bit. A rising transition or a steady level does not.
- R5: Mode code 2 (rising edge): a low-to-high transition sets the pending bit. A falling transition or a steady level does not.
- R6: Mode code 3 (both edges): either transition sets the pending bit. A steady level does not.
- R7: A pin change driven between clock edges shows on `irq_o` after the third following rising clock edge, and not after the second.
- R8: A pending bit stays set until software writes 0 to it at the pending offset. Writing 1 to it has no effect.
- R9: In low-level mode, a clear written while the pin is still low leaves the bit set.
- R10: When a detected edge and a clear write reach the same pending bit in the same cycle, the bit ends up set.
- R11: `irq_o[n]` is high exactly while pending bit n is set.
- R12: Events on one pin never set another pin's pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | External interrupt pins, asynchronous |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i`, combinational |
| irq_o | output | NUM_PINS | Active-high level requests to the parent controller |

## Verification
The bench builds the unit with its default values: eight pins, an 8-bit offset, a 32-bit data word and pending and mode registers at 0x10 and 0x14. With these values the mode word fills its lower sixteen bits, so the bench can check that the upper half reads zero. The stimulus table rotates across all eight pins and compares the whole pending word each time. This shows that every pin's field position is decoded and that no event spills onto a neighbouring pin. Directed tests then time the three-edge latency and place a clear write on the exact edge where a new event lands.

// File: rtl/pin_sense_pkg.sv
package pin_sense_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_mode_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // reset high: idle pins are high, so no false low event after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_event.sv
module pin_event
  import pin_sense_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        lvl_i,
  input  sense_mode_e mode_i,
  input  logic        clr_i,
  output logic        pend_o
);
  logic prev_q, pend_q, hit;

  always_comb begin
    unique case (mode_i)
      SENSE_LOW:  hit = ~lvl_i;
      SENSE_FALL: hit = prev_q & ~lvl_i;
      SENSE_RISE: hit = ~prev_q & lvl_i;
      default:    hit = prev_q ^ lvl_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= (pend_q & ~clr_i) | hit; // set has priority over clear
    end
  end

  assign pend_o = pend_q;

  AST_LOW_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_LOW && !lvl_i) |=> pend_o); // R3
  AST_FALL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_FALL && !lvl_i && $past(lvl_i)) |=> pend_o); // R4
  AST_RISE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_RISE && lvl_i && !$past(lvl_i)) |=> pend_o); // R5
  AST_BOTH_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_BOTH && !$stable(lvl_i)) |=> pend_o); // R6
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i) |=> pend_o); // R8
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && lvl_i && $stable(lvl_i) && mode_i != SENSE_LOW) |=> !pend_o); // R8
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && mode_i == SENSE_BOTH && !$stable(lvl_i)) |=> pend_o); // R10
endmodule

// File: rtl/sense_regs.sv
module sense_regs #(
  parameter int          NUM_PINS = 8,
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] MODE_OFS = 8'h14,
  localparam int         MODE_W   = 2 * NUM_PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [NUM_PINS-1:0] stat_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [NUM_PINS-1:0] clr_o,
  output logic [DATA_W-1:0] bus_rdata_o
);
  logic [MODE_W-1:0] mode_q;
  logic wr_stat, wr_mode;

  assign wr_stat = bus_en_i && bus_we_i && (bus_addr_i == STAT_OFS);
  assign wr_mode = bus_en_i && bus_we_i && (bus_addr_i == MODE_OFS);

  // write-zero-to-clear
  assign clr_o = wr_stat ? ~bus_wdata_i[NUM_PINS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (wr_mode) mode_q <= bus_wdata_i[MODE_W-1:0];
  end

  always_comb begin
    if (bus_addr_i == STAT_OFS)      bus_rdata_o = DATA_W'(stat_i);
    else if (bus_addr_i == MODE_OFS) bus_rdata_o = DATA_W'(mode_q);
    else                             bus_rdata_o = '0;
  end

  assign mode_o = mode_q;

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mode |=> $stable(mode_o)); // R2
  AST_CLR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_o) |-> (bus_en_i && bus_we_i)); // R8
endmodule

// File: rtl/pin_sense_top.sv
module pin_sense_top
  import pin_sense_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] MODE_OFS = 8'h14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                bus_en_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic [NUM_PINS-1:0] irq_o
);
  localparam int MODE_W = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] lvl, clr, pend;
  logic [MODE_W-1:0]   mode;

  pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(lvl)
  );

  sense_regs #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STAT_OFS(STAT_OFS), .MODE_OFS(MODE_OFS)
  ) u_regs (
    .clk_i, .rst_ni, .bus_en_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .stat_i(pend), .mode_o(mode), .clr_o(clr), .bus_rdata_o
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_event u_evt (
      .clk_i, .rst_ni,
      .lvl_i (lvl[p]),
      .mode_i(sense_mode_e'(mode[2*p +: 2])),
      .clr_i (clr[p]),
      .pend_o(pend[p])
    );
  end

  assign irq_o = pend;

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> (irq_o == '0)); // R1
endmodule

// File: tb/pin_sense_top_tb_top.sv
`timescale 1ns/1ps
module pin_sense_top_tb_top;
  localparam logic [7:0] STAT = 8'h10;
  localparam logic [7:0] MODE = 8'h14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  pins = '1;
  logic        en = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  irq;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pin_sense_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .bus_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // {mode[1:0], level before, level after, expected pending}
  localparam logic [4:0] VEC [0:11] = '{
    5'b00_1_1_0, 5'b00_1_0_1, 5'b00_0_1_1,
    5'b01_1_0_1, 5'b01_0_1_0, 5'b01_1_1_0,
    5'b10_0_1_1, 5'b10_1_0_0, 5'b10_0_0_0,
    5'b11_1_0_1, 5'b11_0_1_1, 5'b11_0_0_0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); en = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic settle();
    pins = '1;
    wr(MODE, 32'h0);
    repeat (4) @(negedge clk);
    wr(STAT, 32'h0);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rd(STAT, d); chk("R1 pending after reset", d, 32'h0);
    rd(MODE, d); chk("R1 mode after reset", d, 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);

    // R2 register map
    wr(MODE, 32'hFFFF_FFFF);
    rd(MODE, d); chk("R2 mode upper bits zero", d, 32'h0000_FFFF);
    wr(8'h18, 32'h0);
    rd(MODE, d); chk("R2 unmapped write ignored", d, 32'h0000_FFFF);
    rd(8'h18, d); chk("R2 unmapped read zero", d, 32'h0);
    rd(8'h00, d); chk("R2 offset 0 reads zero", d, 32'h0);
    wr(MODE, 32'h0);

    // table: R3..R6, R12, R11
    for (int k = 0; k < 12; k++) begin
      int p;
      logic [31:0] expw;
      p = k % 8;
      settle();
      wr(MODE, 32'(VEC[k][4:3]) << (2*p));
      pins[p] = VEC[k][2];
      repeat (5) @(negedge clk);
      wr(STAT, 32'h0);
      repeat (2) @(negedge clk);
      pins[p] = VEC[k][1];
      repeat (5) @(negedge clk);
      rd(STAT, d);
      expw = 32'(VEC[k][0]) << p;
      chk($sformatf("R3-6 R12 vector %0d mode %0d", k, VEC[k][4:3]), d, expw);
      chk($sformatf("R11 irq vector %0d", k), 32'(irq), expw);
    end

    // R7 latency, pin 3 falling edge
    settle();
    wr(MODE, 32'(2'd1) << 6);
    repeat (2) @(negedge clk);
    pins[3] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); chk("R7 not after second edge", 32'(irq), 32'h0);
    @(posedge clk);
    @(negedge clk); chk("R7 set after third edge", 32'(irq), 32'h08);

    // R8 sticky / clear
    wr(STAT, 32'hFFFF_FFFF);
    rd(STAT, d); chk("R8 write one keeps bit", d, 32'h08);
    wr(STAT, 32'hFFFF_FFF7);
    rd(STAT, d); chk("R8 write zero clears", d, 32'h0);
    chk("R8 R11 irq drops", 32'(irq), 32'h0);

    // R9 low level clear while low
    settle();
    pins[6] = 1'b0;
    repeat (4) @(negedge clk);
    wr(STAT, 32'h0);
    rd(STAT, d); chk("R9 clear while low ignored", d, 32'h40);
    pins[6] = 1'b1;
    repeat (4) @(negedge clk);
    wr(STAT, 32'h0);
    rd(STAT, d); chk("R9 clear after release", d, 32'h0);

    // R10 set wins: pin 5 both edges, clear on the edge the rise lands
    settle();
    wr(MODE, 32'(2'd3) << 10);
    pins[5] = 1'b0;
    repeat (5) @(negedge clk);
    rd(STAT, d); chk("R6 fall pending before race", d, 32'h20);
    @(negedge clk); pins[5] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); en = 1'b1; we = 1'b1; addr = STAT; wdata = 32'h0;
    @(negedge clk); en = 1'b0; we = 1'b0;
    rd(STAT, d); chk("R10 set wins over clear", d, 32'h20);
    wr(STAT, 32'h0);
    rd(STAT, d); chk("R10 later clear works", d, 32'h0);

    report();
  end
endmodule